// File: doc/BRIEF.md
# Accumulator CPU Instruction Sequencer

This block is a compact processor core with one accumulator and hardwired control. A single state machine runs every instruction through the same stages in order. It fetches the opcode word, decodes it, fetches an operand address word when the instruction needs one, executes, and then performs a store when the instruction calls for it. After that it starts the next instruction. The datapath holds the usual registers: a program counter, a memory address register, a memory data register, an opcode register, an operand address register and the accumulator. It also keeps three status bits, halted, zero and negative.

Memory is organised in words and addressed in bytes, so the program counter advances by the word size in bytes for each word it fetches. The core makes at most one memory access per state. In that state it drives a valid address, a read/write strobe and a data-size code. Read data is sampled into the data register on the clock edge that ends the access. Four instructions exist: add a memory word to the accumulator, store the accumulator, jump, and halt. Any opcode the decoder does not recognise stops the core in the same way as halt.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high and right after it is released, `pc_out`, `acc_out`, `flag_h`, `flag_z` and `flag_n` are all zero. The first access after release is a read of address 0x0000.
- R2: Each instruction begins with an idle cycle. Next comes one read cycle at the current PC, and at the end of that cycle the PC increases by 2. The PC is 2 on the second clock after reset release.
- R3: Opcode 0x0099 (add) reads the following word as an operand address. It then reads the word at that address and sets A to (A + word) mod 2^16. The add takes 9 clock cycles in total.
- R4: After an add, `flag_n` equals bit 15 of A, and `flag_z` is 1 exactly when A is zero.
- R5: Opcode 0x0098 (store) reads the following word as an address and writes A there in a single write cycle. During the write, `mem_rw` is 0 and `mem_wdata` equals A. A, `flag_z` and `flag_n` are left unchanged. The store takes 8 cycles.
- R6: Opcode 0x0097 (jump) reads the following word and loads it into the PC, so the next opcode is fetched from that address. A and the flags are left unchanged, and the jump takes 7 cycles.
- R7: Opcode 0x0000 (halt) sets `flag_h` 3 cycles after its fetch begins. At that point the PC is the halt address plus 2. From then on there is no memory access, and the PC, A and the flags hold their values until reset.
- R8: Any opcode other than 0x0099, 0x0098, 0x0097 and 0x0000 acts exactly like halt. It causes no write, and A and the flags stay as they were.
- R9: Every access has `mem_valid` high for one cycle. `mem_rw` is 1 for a read and 0 for a write, and `mem_size` is 2'b01 (word). Read data is captured at the clock edge that ends the valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_valid | output | 1 | An access is in progress in this cycle |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_size | output | 2 | Data-size code, 2'b01 = word |
| mem_addr | output | ADDR_W (16) | Byte address taken from the address register |
| mem_wdata | output | DATA_W (16) | Data written on a store |
| mem_rdata | input | DATA_W (16) | Read data, valid during a read cycle |
| acc_out | output | DATA_W (16) | Accumulator |
| pc_out | output | ADDR_W (16) | Program counter |
| flag_h | output | 1 | Halted status bit |
| flag_z | output | 1 | Zero status bit |
| flag_n | output | 1 | Negative status bit |

## Verification
The bound checker watches, on every cycle, the properties that can be stated in terms of state. Halt is sticky, and once halted the core makes no access and its PC does not move. Any change of the accumulator is accompanied by matching Z and N values, a write leaves the accumulator untouched, and every access uses the word size code. The bench scenarios are needed for the rest. They show the sums with modular wraparound, the exact cycle counts of each instruction, the write address and data that land in memory, where a jump redirects the PC, and that unknown opcodes leave memory and the accumulator untouched.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [3:0] {
      ST_FADDR,
      ST_FREAD,
      ST_DECODE,
      ST_OADDR,
      ST_OREAD,
      ST_OLATCH,
      ST_EXADDR,
      ST_EXREAD,
      ST_ALU,
      ST_STORE,
      ST_HALT
   } seq_state_t;

   typedef enum logic [1:0] {
      K_HALT,
      K_ADD,
      K_STORE,
      K_JUMP
   } op_kind_t;

   typedef struct packed {
      logic mar_from_pc;
      logic mar_from_opa;
      logic mem_rd;
      logic mem_wr;
      logic pc_inc;
      logic pc_load;
      logic opa_load;
      logic acc_load;
      logic halt_set;
   } ctl_t;

   localparam logic [15:0] OPC_ADD   = 16'h0099;
   localparam logic [15:0] OPC_STORE = 16'h0098;
   localparam logic [15:0] OPC_JUMP  = 16'h0097;
   localparam logic [1:0]  SIZE_WORD = 2'b01;

   function automatic op_kind_t classify(input logic [15:0] code);
      op_kind_t k;
      case (code)
         OPC_ADD:   k = K_ADD;
         OPC_STORE: k = K_STORE;
         OPC_JUMP:  k = K_JUMP;
         default:   k = K_HALT;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] sum,
   output logic          zero,
   output logic          neg
);
   always_comb begin
      sum  = a + b;
      zero = (sum == '0);
      neg  = sum[DW-1];
   end
endmodule

// File: rtl/acc_cpu_pc.sv
module acc_cpu_pc #(
   parameter int AW   = 16,
   parameter int STEP = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   output logic [AW-1:0] pc
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
      end else if (load) begin
         pc <= load_val;
      end else if (inc) begin
         pc <= pc + STEP_V;
      end
   end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] mdr,
   output ctl_t          ctl
);
   seq_state_t    state, state_nx;
   logic [DW-1:0] opcode;
   logic          hi_mdr, hi_opc;
   op_kind_t      kind_mdr, kind_opc;

   generate
      if (DW > 16) begin : g_wide
         assign hi_mdr = |mdr[DW-1:16];
         assign hi_opc = |opcode[DW-1:16];
      end else begin : g_narrow
         assign hi_mdr = 1'b0;
         assign hi_opc = 1'b0;
      end
   endgenerate

   assign kind_mdr = hi_mdr ? K_HALT : classify(mdr[15:0]);
   assign kind_opc = hi_opc ? K_HALT : classify(opcode[15:0]);

   always_comb begin
      ctl      = '0;
      state_nx = state;
      case (state)
         ST_FADDR: begin
            ctl.mar_from_pc = 1'b1;
            state_nx        = ST_FREAD;
         end
         ST_FREAD: begin
            ctl.mem_rd = 1'b1;
            ctl.pc_inc = 1'b1;
            state_nx   = ST_DECODE;
         end
         ST_DECODE: begin
            if (kind_mdr == K_HALT) begin
               ctl.halt_set = 1'b1;
               state_nx     = ST_HALT;
            end else begin
               state_nx = ST_OADDR;
            end
         end
         ST_OADDR: begin
            ctl.mar_from_pc = 1'b1;
            state_nx        = ST_OREAD;
         end
         ST_OREAD: begin
            ctl.mem_rd = 1'b1;
            ctl.pc_inc = 1'b1;
            state_nx   = ST_OLATCH;
         end
         ST_OLATCH: begin
            ctl.opa_load = 1'b1;
            state_nx     = ST_EXADDR;
         end
         ST_EXADDR: begin
            case (kind_opc)
               K_JUMP: begin
                  ctl.pc_load = 1'b1;
                  state_nx    = ST_FADDR;
               end
               K_ADD: begin
                  ctl.mar_from_opa = 1'b1;
                  state_nx         = ST_EXREAD;
               end
               K_STORE: begin
                  ctl.mar_from_opa = 1'b1;
                  state_nx         = ST_STORE;
               end
               default: state_nx = ST_FADDR;
            endcase
         end
         ST_EXREAD: begin
            ctl.mem_rd = 1'b1;
            state_nx   = ST_ALU;
         end
         ST_ALU: begin
            ctl.acc_load = 1'b1;
            state_nx     = ST_FADDR;
         end
         ST_STORE: begin
            ctl.mem_wr = 1'b1;
            state_nx   = ST_FADDR;
         end
         ST_HALT:  state_nx = ST_HALT;
         default:  state_nx = ST_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_FADDR;
         opcode <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_DECODE) begin
            opcode <= mdr;
         end
      end
   end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   output logic              mem_valid,
   output logic              mem_rw,
   output logic [1:0]        mem_size,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] acc_out,
   output logic [ADDR_W-1:0] pc_out,
   output logic              flag_h,
   output logic              flag_z,
   output logic              flag_n
);
   localparam int PC_STEP = DATA_W / 8;

   generate
      if (DATA_W < 16) begin : g_bad_dw
         $error("DATA_W must be at least 16 to hold the opcodes");
      end
      if ((DATA_W % 8) != 0) begin : g_bad_bytes
         $error("DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("ADDR_W too small");
      end
   endgenerate

   ctl_t              ctl;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] mdr;
   logic [DATA_W-1:0] opa;
   logic [ADDR_W-1:0] opa_addr;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] alu_sum;
   logic              alu_zero, alu_neg;
   logic              fh, fz, fn;

   generate
      if (ADDR_W <= DATA_W) begin : g_addr_trunc
         assign opa_addr = opa[ADDR_W-1:0];
      end else begin : g_addr_ext
         assign opa_addr = {{(ADDR_W-DATA_W){1'b0}}, opa};
      end
   endgenerate

   acc_cpu_ctrl #(.DW(DATA_W)) u_ctrl (
      .clk (clk),
      .rst (rst),
      .mdr (mdr),
      .ctl (ctl)
   );

   acc_cpu_pc #(.AW(ADDR_W), .STEP(PC_STEP)) u_pc (
      .clk      (clk),
      .rst      (rst),
      .inc      (ctl.pc_inc),
      .load     (ctl.pc_load),
      .load_val (opa_addr),
      .pc       (pc_out)
   );

   acc_cpu_alu #(.DW(DATA_W)) u_alu (
      .a    (acc),
      .b    (mdr),
      .sum  (alu_sum),
      .zero (alu_zero),
      .neg  (alu_neg)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mar <= '0;
         mdr <= '0;
         opa <= '0;
         acc <= '0;
         fh  <= 1'b0;
         fz  <= 1'b0;
         fn  <= 1'b0;
      end else begin
         if (ctl.mar_from_pc) begin
            mar <= pc_out;
         end else if (ctl.mar_from_opa) begin
            mar <= opa_addr;
         end
         if (ctl.mem_rd) begin
            mdr <= mem_rdata;
         end
         if (ctl.opa_load) begin
            opa <= mdr;
         end
         if (ctl.acc_load) begin
            acc <= alu_sum;
            fz  <= alu_zero;
            fn  <= alu_neg;
         end
         if (ctl.halt_set) begin
            fh <= 1'b1;
         end
      end
   end

   assign mem_valid = ctl.mem_rd | ctl.mem_wr;
   assign mem_rw    = ~ctl.mem_wr;
   assign mem_size  = mem_valid ? SIZE_WORD : 2'b00;
   assign mem_addr  = mar;
   assign mem_wdata = acc;
   assign acc_out   = acc;
   assign flag_h    = fh;
   assign flag_z    = fz;
   assign flag_n    = fn;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int DW = 16,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          mem_valid,
   input logic          mem_rw,
   input logic [1:0]    mem_size,
   input logic [DW-1:0] acc_out,
   input logic [AW-1:0] pc_out,
   input logic          flag_h,
   input logic          flag_z,
   input logic          flag_n
);
   assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      flag_h |=> flag_h);

   assert_halt_idle_R7: assert property (@(posedge clk) disable iff (rst)
      flag_h |-> !mem_valid);

   assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (rst)
      flag_h |=> $stable(pc_out));

   assert_flags_track_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(acc_out) |-> ((flag_n == acc_out[DW-1]) && (flag_z == (acc_out == '0))));

   assert_store_keeps_acc_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && !mem_rw) |=> $stable(acc_out));

   assert_word_size_R9: assert property (@(posedge clk) disable iff (rst)
      mem_valid |-> (mem_size == 2'b01));
endmodule

bind acc_cpu_core acc_cpu_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mem_valid (mem_valid),
   .mem_rw    (mem_rw),
   .mem_size  (mem_size),
   .acc_out   (acc_out),
   .pc_out    (pc_out),
   .flag_h    (flag_h),
   .flag_z    (flag_z),
   .flag_n    (flag_n)
);

// File: tb/sim_acc_cpu_core.sv
`timescale 1ns/1ps
module sim_acc_cpu_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mem_valid, mem_rw;
   logic [1:0]  mem_size;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic [15:0] acc_out, pc_out;
   logic        flag_h, flag_z, flag_n;

   always #10 clk = ~clk;

   acc_cpu_core u0 (
      .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_rw(mem_rw),
      .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .acc_out(acc_out), .pc_out(pc_out),
      .flag_h(flag_h), .flag_z(flag_z), .flag_n(flag_n)
   );

   logic [15:0] mem [32];
   logic [15:0] prog [32];
   logic        ld_en = 1'b0;
   logic [4:0]  ld_idx = '0;
   logic [15:0] ld_val = '0;

   always @(posedge clk) begin
      if (ld_en) mem[ld_idx] <= ld_val;
      else if (mem_valid && !mem_rw) mem[mem_addr[5:1]] <= mem_wdata;
   end
   assign mem_rdata = mem[mem_addr[5:1]];

   int          wr_count;
   logic [15:0] wr_addr, wr_data;
   always @(negedge clk) begin
      if (rst) wr_count <= 0;
      else if (mem_valid && !mem_rw) begin
         wr_count <= wr_count + 1;
         wr_addr  <= mem_addr;
         wr_data  <= mem_wdata;
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   int cyc;
   bit done = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run(input bit probe);
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 32; i++) begin
         ld_en = 1'b1; ld_idx = 5'(i); ld_val = prog[i];
         @(negedge clk);
      end
      ld_en = 1'b0;
      @(negedge clk);
      if (probe) begin
         chk("R1", "pc in reset", 32'(pc_out), 0);
         chk("R1", "acc in reset", 32'(acc_out), 0);
         chk("R1", "flags h,z,n in reset", {29'd0, flag_h, flag_z, flag_n}, 0);
      end
      rst = 1'b0;
      cyc = 0;
      while (!flag_h && cyc < 400) begin
         @(negedge clk);
         cyc++;
         if (probe && cyc == 1) begin
            chk("R1", "first access valid", 32'(mem_valid), 1);
            chk("R9", "first access is read", 32'(mem_rw), 1);
            chk("R1", "first access address", 32'(mem_addr), 0);
            chk("R9", "size code word", 32'(mem_size), 1);
            chk("R2", "pc before fetch edge", 32'(pc_out), 0);
         end
         if (probe && cyc == 2) begin
            chk("R2", "pc after opcode fetch", 32'(pc_out), 2);
            chk("R9", "no access in decode", 32'(mem_valid), 0);
         end
      end
   endtask

   task automatic check_frozen(input string req);
      logic [15:0] p, a;
      p = pc_out; a = acc_out;
      repeat (4) @(negedge clk);
      chk(req, "pc frozen after halt", 32'(pc_out), 32'(p));
      chk(req, "acc frozen after halt", 32'(acc_out), 32'(a));
      chk(req, "no access after halt", 32'(mem_valid), 0);
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 32; i++) prog[i] = 16'h0000;
      prog[18] = 16'hDEAD;
   endtask

   function automatic logic [15:0] opnd_x(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h7FFF;
         2: return 16'hFFFF;
         3: return 16'h8000;
         4: return 16'h1234;
         default: return 16'(i * 16'h1F3B + 7);
      endcase
   endfunction

   function automatic logic [15:0] opnd_y(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h0001;
         3: return 16'h8000;
         4: return 16'hEDCB;
         default: return 16'(i * 16'h0C05) ^ 16'h5A5A;
      endcase
   endfunction

   initial begin
      logic [15:0] x, y, s;
      logic [15:0] codes [6];
      codes[0] = 16'h0001; codes[1] = 16'h0096; codes[2] = 16'h009A;
      codes[3] = 16'h1234; codes[4] = 16'hFFFF; codes[5] = 16'h0000;

      // Add sweep: ADD x; ADD y; STORE 0x24; HALT  (R3, R4, R5, R7, R9)
      for (int i = 0; i < 30; i++) begin
         x = opnd_x(i); y = opnd_y(i); s = x + y;
         clear_prog();
         prog[0] = 16'h0099; prog[1] = 16'h0020;
         prog[2] = 16'h0099; prog[3] = 16'h0022;
         prog[4] = 16'h0098; prog[5] = 16'h0024;
         prog[6] = 16'h0000;
         prog[16] = x; prog[17] = y;
         run(i == 0);
         chk("R3", "cycles add,add,store,halt", 32'(cyc), 29);
         chk("R3", "acc sum", 32'(acc_out), 32'(s));
         chk("R4", "flag_z", 32'(flag_z), 32'(s == 16'h0000));
         chk("R4", "flag_n", 32'(flag_n), 32'(s[15]));
         chk("R7", "pc after halt", 32'(pc_out), 32'h0E);
         chk("R5", "stored word", 32'(mem[18]), 32'(s));
         chk("R5", "write count", 32'(wr_count), 1);
         chk("R9", "write address", 32'(wr_addr), 32'h24);
         chk("R5", "write data", 32'(wr_data), 32'(s));
         if (i < 3) check_frozen("R7");
      end

      // Jump: ADD x; JUMP 0x0A; (HALT skipped); STORE 0x24; HALT  (R6)
      for (int i = 0; i < 4; i++) begin
         x = (i == 0) ? 16'h8000 : (i == 1) ? 16'h0000 : 16'(i * 16'h2345);
         clear_prog();
         prog[0] = 16'h0099; prog[1] = 16'h0020;
         prog[2] = 16'h0097; prog[3] = 16'h000A;
         prog[4] = 16'h0000;
         prog[5] = 16'h0098; prog[6] = 16'h0024;
         prog[7] = 16'h0000;
         prog[16] = x;
         run(1'b0);
         chk("R6", "cycles add,jump,store,halt", 32'(cyc), 27);
         chk("R6", "pc after halt past jump", 32'(pc_out), 32'h10);
         chk("R6", "acc after jump", 32'(acc_out), 32'(x));
         chk("R6", "stored after jump", 32'(mem[18]), 32'(x));
         chk("R6", "flag_z kept", 32'(flag_z), 32'(x == 16'h0000));
         chk("R6", "flag_n kept", 32'(flag_n), 32'(x[15]));
      end

      // Unknown opcodes and plain halt (R7, R8)
      for (int i = 0; i < 6; i++) begin
         clear_prog();
         prog[0] = codes[i]; prog[1] = 16'h0020;
         prog[2] = 16'h0098; prog[3] = 16'h0024;
         prog[16] = 16'h5555;
         run(1'b0);
         chk(i == 5 ? "R7" : "R8", "cycles to halt", 32'(cyc), 3);
         chk(i == 5 ? "R7" : "R8", "pc at halt", 32'(pc_out), 2);
         chk("R8", "acc untouched", 32'(acc_out), 0);
         chk("R8", "flags z,n untouched", {30'd0, flag_z, flag_n}, 0);
         chk("R8", "no write", 32'(wr_count), 0);
         chk("R8", "memory untouched", 32'(mem[18]), 32'hDEAD);
         if (i == 3) check_frozen("R8");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule